// File: doc/BRIEF.md
# Multiplexed Seven-Segment Refresh Controller

This block drives a time-multiplexed seven-segment display from a 16-entry, 8-bit display memory. A CPU port writes any entry and reads any entry back. Independently of the CPU, a sequencer steps through the digit positions. For each position it shows the stored byte on two 4-bit segment groups, holds it for a programmable number of scan ticks, and then blanks the display for a short gap before it moves on to the next position.

The current digit position appears on four scan lines. The lines carry either a binary index for an external decoder, or a one-hot pattern that selects one of four digits directly. In binary mode, one input selects whether the index wraps after 8 or after 16 digits. All timing is counted in cycles of a scan-tick enable, so the caller sets the refresh rate by choosing how often the tick is raised.

The sequencer is a two-state machine. In state ST_BLANK, the segments carry the blank code and the blank output is low. When the gap count expires on a tick, the transition BLANK->SHOW latches the memory byte for the current digit. In state ST_SHOW, that latched byte is driven and the blank output is high. When the dwell count expires on a tick, the transition SHOW->BLANK advances the digit index. When the index reaches the wrap limit, it returns to 0.

Top module: `disp_refresh`

## Requirements
- R1: A CPU write with `cpu_we` high stores `cpu_wdata` at `cpu_addr` on the clock edge. `cpu_rdata` is registered: after each edge it holds the entry addressed by `cpu_addr` at that edge, as it stood before any write on that same edge.
- R2: While a digit is shown, `seg_a` carries bits 7:4 of the byte latched for it and `seg_b` carries bits 3:0.
- R3: With `scan_mode`=0 (binary), `scan_out` is the digit index as a binary number. The index wraps to 0 after 7 when `wide_count`=0, and after 15 when `wide_count`=1.
- R4: With `scan_mode`=1 (one-of-four), `scan_out` is 4'b0001 shifted left by the digit index. The index wraps after 3. Digit k shows memory entry k.
- R5: Digits are shown in ascending index order. Each digit is shown once per round. The index changes only when a show phase ends (at the fall of `blank_n`).
- R6: A show phase lasts DWELL ticks and a blank phase lasts GAP ticks. On a cycle where `tick` is low, the state, the scan lines and the segments do not change.
- R7: During a blank phase, `blank_n` is 0 and both segment groups carry BLANK_CODE (default 8'h00). During a show phase, `blank_n` is 1.
- R8: A write to the entry of the digit now being shown does not alter the segments until that digit's next show phase, and it does not alter the scan order. The new value appears on that next show.
- R9: Reset puts every memory entry at BLANK_CODE, sets `cpu_rdata` to BLANK_CODE and the digit index to 0, and starts in a blank phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Scan-clock enable; all phase timing counts these |
| scan_mode | input | 1 | 0: binary scan index, 1: one-of-four scan |
| wide_count | input | 1 | Binary mode wrap: 0 after 8 digits, 1 after 16 |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 4 | CPU memory address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Registered CPU read data |
| scan_out | output | 4 | Digit select lines |
| seg_a | output | 4 | Segment group A (byte bits 7:4) |
| seg_b | output | 4 | Segment group B (byte bits 3:0) |
| blank_n | output | 1 | Active-low display blank |

## Verification
A read result is due one edge after its address is presented, so the bench sets the address at a falling edge and samples `cpu_rdata` at the next falling edge. Segment and scan values change on the tick edge that ends a phase, so `blank_n` rises on the same edge that latches the segment byte. The bench therefore waits for that rise at a falling edge and then samples the scan lines and segments. Phase lengths are measured by counting consecutive falling edges at each level of `blank_n`, and are compared with DWELL and GAP. Under the half-rate tick these lengths double. Rewrite-during-show is checked in the cycles that remain in the current show phase, and again on the digit's next show, one full round later.

// File: rtl/disp_refresh_pkg.sv
package disp_refresh_pkg;

    typedef enum logic {
        ST_BLANK = 1'b0,
        ST_SHOW  = 1'b1
    } phase_e;

    localparam int SCAN_W = 4;

endpackage

// File: rtl/disp_mem.sv
module disp_mem #(
    parameter int          DEPTH      = 16,
    parameter int          DW         = 8,
    parameter logic [DW-1:0] BLANK_CODE = '0,
    localparam int         AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata_q,
    input  logic [AW-1:0] fetch_addr,
    output logic [DW-1:0] fetch_data
);

    logic [DW-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cells[g] <= BLANK_CODE;
            else if (we && cpu_addr == AW'(g))
                cells[g] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= BLANK_CODE;
        else
            rdata_q <= cells[cpu_addr];
    end

    assign fetch_data = cells[fetch_addr];

endmodule

// File: rtl/scan_seq.sv
module scan_seq
    import disp_refresh_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DWELL = 1000,
    parameter int GAP   = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int MAXC = (DWELL > GAP) ? DWELL : GAP,
    localparam int CW   = $clog2(MAXC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          dec_mode,
    input  logic          wide,
    output phase_e        phase,
    output logic [AW-1:0] digit,
    output logic          load
);

    localparam logic [CW-1:0] DWELL_LAST = CW'(DWELL - 1);
    localparam logic [CW-1:0] GAP_LAST   = CW'(GAP - 1);
    localparam logic [AW-1:0] LAST_DEC   = AW'(3);
    localparam logic [AW-1:0] LAST_WIDE  = AW'(DEPTH - 1);
    localparam logic [AW-1:0] LAST_NARW  = AW'(DEPTH / 2 - 1);

    phase_e        state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [AW-1:0] digit_q, digit_d;
    logic [AW-1:0] wrap_at;

    assign wrap_at = dec_mode ? LAST_DEC : (wide ? LAST_WIDE : LAST_NARW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BLANK;
            cnt_q   <= '0;
            digit_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            digit_q <= digit_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        digit_d = digit_q;
        load    = 1'b0;
        if (tick) begin
            unique case (state_q)
                ST_SHOW: begin
                    if (cnt_q == DWELL_LAST) begin
                        state_d = ST_BLANK;
                        cnt_d   = '0;
                        digit_d = (digit_q >= wrap_at) ? '0 : digit_q + 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_BLANK: begin
                    if (cnt_q == GAP_LAST) begin
                        state_d = ST_SHOW;
                        cnt_d   = '0;
                        load    = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign phase = state_q;
    assign digit = digit_q;

endmodule

// File: rtl/seg_drive.sv
module seg_drive
    import disp_refresh_pkg::*;
#(
    parameter int            DEPTH      = 16,
    parameter int            DW         = 8,
    parameter logic [DW-1:0] BLANK_CODE = '0,
    localparam int           AW         = $clog2(DEPTH),
    localparam int           HW         = DW / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DW-1:0]     fetch_data,
    input  phase_e            phase,
    input  logic [AW-1:0]     digit,
    input  logic              dec_mode,
    output logic [SCAN_W-1:0] scan_out,
    output logic [HW-1:0]     seg_a,
    output logic [HW-1:0]     seg_b,
    output logic              blank_n
);

    logic [DW-1:0] seg_q;
    logic [DW-1:0] shown;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seg_q <= BLANK_CODE;
        else if (load)
            seg_q <= fetch_data;
    end

    always_comb begin
        unique case (phase)
            ST_SHOW:  begin shown = seg_q;      blank_n = 1'b1; end
            ST_BLANK: begin shown = BLANK_CODE; blank_n = 1'b0; end
        endcase
        if (dec_mode)
            scan_out = SCAN_W'(1) << digit[1:0];
        else
            scan_out = SCAN_W'(digit);
    end

    assign seg_a = shown[DW-1:HW];
    assign seg_b = shown[HW-1:0];

endmodule

// File: rtl/disp_refresh.sv
module disp_refresh
    import disp_refresh_pkg::*;
#(
    parameter int            DEPTH      = 16,
    parameter int            DW         = 8,
    parameter int            DWELL      = 1000,
    parameter int            GAP        = 4,
    parameter logic [DW-1:0] BLANK_CODE = '0,
    localparam int           AW         = $clog2(DEPTH),
    localparam int           HW         = DW / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              scan_mode,
    input  logic              wide_count,
    input  logic              cpu_we,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    output logic [SCAN_W-1:0] scan_out,
    output logic [HW-1:0]     seg_a,
    output logic [HW-1:0]     seg_b,
    output logic              blank_n
);

    phase_e        phase;
    logic [AW-1:0] digit;
    logic          load;
    logic [DW-1:0] fetch_data;

    disp_mem #(.DEPTH(DEPTH), .DW(DW), .BLANK_CODE(BLANK_CODE)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cpu_we),
        .cpu_addr   (cpu_addr),
        .wdata      (cpu_wdata),
        .rdata_q    (cpu_rdata),
        .fetch_addr (digit),
        .fetch_data (fetch_data)
    );

    scan_seq #(.DEPTH(DEPTH), .DWELL(DWELL), .GAP(GAP)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .dec_mode (scan_mode),
        .wide     (wide_count),
        .phase    (phase),
        .digit    (digit),
        .load     (load)
    );

    seg_drive #(.DEPTH(DEPTH), .DW(DW), .BLANK_CODE(BLANK_CODE)) u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .fetch_data (fetch_data),
        .phase      (phase),
        .digit      (digit),
        .dec_mode   (scan_mode),
        .scan_out   (scan_out),
        .seg_a      (seg_a),
        .seg_b      (seg_b),
        .blank_n    (blank_n)
    );

endmodule

// File: rtl/disp_refresh_chk.sv
module disp_refresh_chk #(
    parameter int            DW         = 8,
    parameter int            AW         = 4,
    parameter logic [DW-1:0] BLANK_CODE = '0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          scan_mode,
    input logic          wide_count,
    input logic          cpu_we,
    input logic [AW-1:0] cpu_addr,
    input logic [DW-1:0] cpu_wdata,
    input logic [DW-1:0] cpu_rdata,
    input logic [3:0]    scan_out,
    input logic [DW/2-1:0] seg_a,
    input logic [DW/2-1:0] seg_b,
    input logic          blank_n
);

    p_rd_after_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we ##1 (!cpu_we && cpu_addr == $past(cpu_addr)) |=> cpu_rdata == $past(cpu_wdata, 2));

    p_enc_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_mode && !wide_count) |-> scan_out < 4'd8);

    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_mode |-> $countones(scan_out) == 1);

    p_scan_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(scan_mode) && $stable(wide_count) && !$fell(blank_n)) |-> $stable(scan_out));

    p_no_tick_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(blank_n) && $stable(scan_out) && $stable({seg_a, seg_b})));

    p_blank_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |-> {seg_a, seg_b} == BLANK_CODE);

    p_show_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && $past(blank_n)) |-> $stable({seg_a, seg_b}));

endmodule

bind disp_refresh disp_refresh_chk #(.DW(DW), .AW(AW), .BLANK_CODE(BLANK_CODE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .scan_mode  (scan_mode),
    .wide_count (wide_count),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rdata  (cpu_rdata),
    .scan_out   (scan_out),
    .seg_a      (seg_a),
    .seg_b      (seg_b),
    .blank_n    (blank_n)
);

// File: tb/tb_disp_refresh.sv
`timescale 1ns/1ps
module tb_disp_refresh;

    localparam int DWELL = 4;
    localparam int GAP   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       scan_mode = 1'b0;
    logic       wide_count = 1'b0;
    logic       cpu_we = 1'b0;
    logic [3:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [3:0] scan_out;
    logic [3:0] seg_a, seg_b;
    logic       blank_n;

    logic       tick_half = 1'b0;
    logic       tick_stop = 1'b0;
    logic [7:0] exp_mem [16];
    int         n_tests = 0;
    int         n_fail  = 0;
    int         cycles  = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        tick <= tick_stop ? 1'b0 : (tick_half ? ~tick : 1'b1);
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    disp_refresh #(.DWELL(DWELL), .GAP(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .scan_mode(scan_mode),
        .wide_count(wide_count), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .scan_out(scan_out),
        .seg_a(seg_a), .seg_b(seg_b), .blank_n(blank_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic dec, input logic wide);
        @(negedge clk);
        rst_n = 1'b0;
        scan_mode = dec;
        wide_count = wide;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) exp_mem[i] = 8'h00;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        cpu_we = 1'b1;
        cpu_addr = 4'(a);
        cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
        exp_mem[a] = d;
    endtask

    task automatic load_all();
        for (int i = 0; i < 16; i++) wr(i, 8'((i * 8'h25) ^ 8'h9C));
    endtask

    task automatic wait_show();
        logic prev;
        int   guard;
        prev = blank_n;
        guard = 0;
        while (guard < 1000) begin
            @(negedge clk);
            guard++;
            if (blank_n && !prev) return;
            prev = blank_n;
        end
        chk(1'b0, "wait_show timeout", guard, 0);
    endtask

    task automatic t_reset();
        do_reset(1'b0, 1'b0);
        chk(blank_n == 1'b0, "R9 blank at reset", blank_n, 0);
        chk(scan_out == 4'd0, "R9 index 0 at reset", scan_out, 0);
        chk(cpu_rdata == 8'h00, "R9 rdata at reset", cpu_rdata, 0);
        chk({seg_a, seg_b} == 8'h00, "R9 segs at reset", {seg_a, seg_b}, 0);
    endtask

    task automatic t_mem_rw();
        load_all();
        for (int i = 0; i < 16; i++) begin
            cpu_addr = 4'(15 - i);
            @(negedge clk);
            chk(cpu_rdata == exp_mem[15 - i], "R1 readback", cpu_rdata, exp_mem[15 - i]);
        end
    endtask

    task automatic t_scan(input logic dec, input logic wide, input int ndig);
        do_reset(dec, wide);
        load_all();
        wait_show();
        while (scan_out != (dec ? 4'b0001 : 4'd0)) wait_show();
        for (int i = 0; i < ndig + 2; i++) begin
            int d;
            d = i % ndig;
            if (dec)
                chk(scan_out == 4'(1 << d), "R4 one-hot scan", scan_out, 1 << d);
            else
                chk(scan_out == 4'(d), "R3 binary scan wrap", scan_out, d);
            chk({seg_a, seg_b} == exp_mem[d], "R2 R5 segment byte", {seg_a, seg_b}, exp_mem[d]);
            chk(seg_a == exp_mem[d][7:4], "R2 group A", seg_a, exp_mem[d][7:4]);
            wait_show();
        end
    endtask

    task automatic t_timing();
        int hi, lo;
        for (int pass = 0; pass < 2; pass++) begin
            tick_half = (pass == 1);
            wait_show();
            hi = 1; lo = 0;
            @(negedge clk);
            while (blank_n) begin hi++; @(negedge clk); end
            while (!blank_n) begin
                chk({seg_a, seg_b} == 8'h00, "R7 blank code", {seg_a, seg_b}, 0);
                lo++;
                @(negedge clk);
            end
            chk(hi == DWELL * (pass + 1), "R6 show length", hi, DWELL * (pass + 1));
            chk(lo == GAP * (pass + 1), "R6 blank length", lo, GAP * (pass + 1));
        end
        tick_half = 1'b0;
        begin
            logic [3:0] s;
            logic       b;
            @(negedge clk);
            tick_stop = 1'b1;
            @(negedge clk);
            s = scan_out; b = blank_n;
            repeat (20) @(negedge clk);
            chk(scan_out == s && blank_n == b, "R6 frozen without tick", {scan_out, 3'b0, blank_n}, {s, 3'b0, b});
            tick_stop = 1'b0;
        end
    endtask

    task automatic t_update();
        logic [3:0] d;
        logic [7:0] old;
        do_reset(1'b0, 1'b0);
        load_all();
        wait_show();
        d = scan_out;
        old = {seg_a, seg_b};
        wr(d, 8'h5A);
        chk({seg_a, seg_b} == old && blank_n, "R8 held this show", {seg_a, seg_b}, old);
        @(negedge clk);
        chk({seg_a, seg_b} == old, "R8 held later", {seg_a, seg_b}, old);
        wait_show();
        chk(scan_out == 4'((d + 1) % 8), "R8 order kept", scan_out, (d + 1) % 8);
        for (int i = 0; i < 7; i++) wait_show();
        chk(scan_out == d, "R8 back at digit", scan_out, d);
        chk({seg_a, seg_b} == 8'h5A, "R8 new value shown", {seg_a, seg_b}, 8'h5A);
    endtask

    task automatic t_reset_clear();
        load_all();
        do_reset(1'b0, 1'b0);
        for (int i = 0; i < 16; i += 5) begin
            cpu_addr = 4'(i);
            @(negedge clk);
            chk(cpu_rdata == 8'h00, "R9 memory cleared", cpu_rdata, 0);
        end
    endtask

    initial begin
        t_reset();
        t_mem_rw();
        t_scan(1'b0, 1'b0, 8);
        t_scan(1'b0, 1'b1, 16);
        t_scan(1'b1, 1'b0, 4);
        t_timing();
        t_update();
        t_reset_clear();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule